// File: doc/BRIEF.md
# Depth-Cascadable FIFO Cell

This block is a first-in first-out buffer built from one or more identical cells. Each cell stores DEPTH words of WIDTH bits and can run alone or as one member of a ring of cells that together act as one deeper buffer. A write happens on the rising (release) edge of an active-low write strobe, and a read retires the oldest word on the rising edge of an active-low read strobe. Both strobes are sampled on the system clock. Flags are active-low: empty, full and, for a lone cell, half-full. A lone cell can also rewind its read position to location zero, so that stored data can be read again.

In a ring, two ownership tokens travel from cell to cell over a 2-bit active-low ring link. One token grants the right to write and the other grants the right to read. The lead cell is picked by a strap and holds both tokens after reset. A cell gives up a token after it uses its last location. The top module wires NCELLS cells into a ring, combines their flags into composite flags, and steers the read data from whichever cell holds the read token. Word width grows by placing instances side by side, and the flags may then be taken from any one of them.

The data path uses strobes rather than valid/ready. Back-pressure is carried by the flags: a write strobe released while full is asserted is dropped, and a read strobe released while empty is asserted has no effect. The word at the output is valid whenever empty is deasserted.

Top module: `fifo_cas_chain`

## Requirements
- R1: After reset, empty_n is 0, full_n is 1 and half_n is 1.
- R2: A word on din is stored in the clock cycle where wr_n is seen rising. Words are read back in write order, and dout shows the oldest stored word while empty_n is 1.
- R3: A write released while full_n is 0 is dropped. The stored contents and full_n stay unchanged.
- R4: A read retires the oldest word when rd_n is seen rising. A read released while empty_n is 0 has no effect, and a later write then reads back correctly.
- R5: Read flow-through: if rd_n is held low while a word is written into an empty buffer, empty_n goes to 1 and dout shows that word after the write edge. empty_n returns to 0 once rd_n rises.
- R6: Write flow-through: if wr_n is held low while a word is read from a full buffer, full_n goes to 1 after the read. It returns to 0 once wr_n rises and the pending word is stored.
- R7: On a lone cell, half_n is 0 exactly when the occupancy exceeds DEPTH/2.
- R8: On a lone cell, one sampled low cycle of rewind_n moves the read position to location 0 and sets the occupancy to the write position. Any strobe edge in that same cycle is ignored.
- R9: A ring of NCELLS cells holds NCELLS*DEPTH words in write order. The composite empty_n and full_n are 0 only when every cell asserts that flag.
- R10: At most one cell holds the write token and at most one holds the read token. A token moves only within two cycles of a write edge (write token) or a read edge (read token). Ring link codes are: 2'b10 write-token pulse, 2'b01 read-token pulse, 2'b11 idle, and 2'b00 (tied low) to select stand-alone mode.
- R11: In a ring, half_n stays 1 and rewind_n has no effect.
- R12: empty_n and full_n are never both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_n | input | 1 | Active-low write strobe, store on release |
| din | input | WIDTH | Write data |
| rd_n | input | 1 | Active-low read strobe, retire on release |
| rewind_n | input | 1 | Active-low rewind of read position (lone cell only) |
| dout | output | WIDTH | Oldest stored word |
| empty_n | output | 1 | Active-low composite empty flag |
| full_n | output | 1 | Active-low composite full flag |
| half_n | output | 1 | Active-low half-full flag (lone cell only) |

## Verification
The bench builds two copies. One is a ring of three cells with DEPTH 4, so twelve words wrap both tokens fully around the ring and cross every cell boundary in a short run. The other is a lone cell with DEPTH 8, where half-full has a distinct threshold between four and five words and rewind, both flow-through cases and overfill can be reached. Token uniqueness and token movement are checked on the ring's internal token vectors.

// File: rtl/fifo_cas_pkg.sv
package fifo_cas_pkg;
  // Active-low ring link codes; tying the link low selects stand-alone mode
  typedef enum logic [1:0] {
    XP_SOLO = 2'b00,
    XP_RTOK = 2'b01,
    XP_WTOK = 2'b10,
    XP_IDLE = 2'b11
  } xp_code_e;
endpackage

// File: rtl/fifo_cas_edge.sv
module fifo_cas_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign rise = !prev_q && strobe_n;
endmodule

// File: rtl/fifo_cas_store.sv
module fifo_cas_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_cas_cell.sv
module fifo_cas_cell
  import fifo_cas_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_n,
  input  logic             rewind_n,
  input  logic             lead_n,
  input  xp_code_e         ring_in_n,
  output xp_code_e         ring_out_n,
  output logic [WIDTH-1:0] dout,
  output logic             q_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             wtok,
  output logic             rtok
);
  logic          wr_rise, rd_rise;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          wtok_q, rtok_q;
  xp_code_e      ring_q;

  fifo_cas_edge u_wedge (.clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .rise(wr_rise));
  fifo_cas_edge u_redge (.clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .rise(rd_rise));

  logic solo, have_w, have_r, is_full, is_empty, rt_act, do_wr, do_rd, wlast, rlast;
  assign solo     = (ring_in_n == XP_SOLO);
  assign have_w   = solo || wtok_q;
  assign have_r   = solo || rtok_q;
  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign rt_act   = solo && !rewind_n;
  assign do_wr    = wr_rise && have_w && !is_full && !rt_act;
  assign do_rd    = rd_rise && have_r && !is_empty && !rt_act;
  assign wlast    = (wr_ptr == AW'(DEPTH - 1));
  assign rlast    = (rd_ptr == AW'(DEPTH - 1));

  fifo_cas_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(do_wr), .waddr(wr_ptr), .wdata(din),
    .raddr(rd_ptr), .rdata(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      wtok_q <= !lead_n;
      rtok_q <= !lead_n;
      ring_q <= XP_IDLE;
    end else begin
      ring_q <= XP_IDLE;
      if (!solo && ring_in_n == XP_WTOK) wtok_q <= 1'b1;
      if (!solo && ring_in_n == XP_RTOK) rtok_q <= 1'b1;
      if (rt_act) begin
        rd_ptr <= '0;
        cnt    <= CW'(wr_ptr);
      end else begin
        if (do_wr) begin
          wr_ptr <= wlast ? '0 : wr_ptr + AW'(1);
          if (wlast && !solo) begin
            wtok_q <= 1'b0;
            ring_q <= XP_WTOK;
          end
        end
        // a cell never writes and reads its last location in one cycle:
        // equal pointers mean full (no write) or empty (no read)
        if (do_rd) begin
          rd_ptr <= rlast ? '0 : rd_ptr + AW'(1);
          if (rlast && !solo) begin
            rtok_q <= 1'b0;
            ring_q <= XP_RTOK;
          end
        end
        case ({do_wr, do_rd})
          2'b10:   cnt <= cnt + CW'(1);
          2'b01:   cnt <= cnt - CW'(1);
          default: cnt <= cnt;
        endcase
      end
    end
  end

  assign ring_out_n = ring_q;
  assign q_oe       = have_r;
  assign empty_n    = !is_empty;
  assign full_n     = !is_full;
  assign half_n     = solo ? !(cnt > CW'(DEPTH / 2)) : 1'b1;
  assign wtok       = wtok_q;
  assign rtok       = rtok_q;
endmodule

// File: rtl/fifo_cas_chain.sv
module fifo_cas_chain
  import fifo_cas_pkg::*;
#(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 16,
  parameter int NCELLS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_n,
  input  logic             rewind_n,
  output logic [WIDTH-1:0] dout,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  xp_code_e          ring_v [NCELLS];
  logic [WIDTH-1:0]  q_v    [NCELLS];
  logic [NCELLS-1:0] oe_v, empty_v, full_v, half_v;
  logic [NCELLS-1:0] wtok_all, rtok_all;

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    localparam int PREV = (i + NCELLS - 1) % NCELLS;
    xp_code_e link_in;
    assign link_in = (NCELLS == 1) ? XP_SOLO : ring_v[PREV];

    fifo_cas_cell #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_n(wr_n), .din(din), .rd_n(rd_n), .rewind_n(rewind_n),
      .lead_n(i != 0),
      .ring_in_n(link_in), .ring_out_n(ring_v[i]),
      .dout(q_v[i]), .q_oe(oe_v[i]),
      .empty_n(empty_v[i]), .full_n(full_v[i]), .half_n(half_v[i]),
      .wtok(wtok_all[i]), .rtok(rtok_all[i])
    );
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < NCELLS; k++) begin
      if (oe_v[k]) dout = dout | q_v[k];
    end
  end

  // active-low flags: composite asserts only when all cells assert
  assign empty_n = |empty_v;
  assign full_n  = |full_v;
  assign half_n  = (NCELLS == 1) ? half_v[0] : 1'b1;
endmodule

// File: rtl/fifo_cas_chk.sv
module fifo_cas_chk #(
  parameter int NCELLS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic              rewind_n,
  input logic              empty_n,
  input logic              full_n,
  input logic [NCELLS-1:0] wtok_all,
  input logic [NCELLS-1:0] rtok_all
);
  logic wq, rq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq <= 1'b1;
      rq <= 1'b1;
    end else begin
      wq <= wr_n;
      rq <= rd_n;
    end
  end

  logic wr_e, rd_e;
  assign wr_e = !wq && wr_n;
  assign rd_e = !rq && rd_n;

  p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_e && !rd_e && rewind_n) |=> !full_n);

  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_e && !wr_e && rewind_n) |=> !empty_n);

  p_wtok_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok_all) <= 1);

  p_rtok_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok_all) <= 1);

  p_wtok_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wtok_all) |-> ($past(wr_e) || $past(wr_e, 2)));

  p_rtok_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rtok_all) |-> ($past(rd_e) || $past(rd_e, 2)));
endmodule

bind fifo_cas_chain fifo_cas_chk #(.NCELLS(NCELLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rewind_n(rewind_n),
  .empty_n(empty_n), .full_n(full_n),
  .wtok_all(wtok_all), .rtok_all(rtok_all)
);

// File: tb/fifo_cas_chain_tb.sv
module fifo_cas_chain_tb;
  localparam int W = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic tgt = 1'b0; // 0: ring of three, 1: lone cell
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] din = '0;

  logic c_wr, c_rd, c_rt, s_wr, s_rd, s_rt;
  assign c_wr = tgt ? 1'b1 : wr_n;
  assign c_rd = tgt ? 1'b1 : rd_n;
  assign c_rt = tgt ? 1'b1 : rt_n;
  assign s_wr = tgt ? wr_n : 1'b1;
  assign s_rd = tgt ? rd_n : 1'b1;
  assign s_rt = tgt ? rt_n : 1'b1;

  logic [W-1:0] c_q, s_q;
  logic c_e, c_f, c_h, s_e, s_f, s_h;

  fifo_cas_chain #(.WIDTH(W), .DEPTH(4), .NCELLS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(c_wr), .din(din), .rd_n(c_rd),
    .rewind_n(c_rt), .dout(c_q), .empty_n(c_e), .full_n(c_f), .half_n(c_h));

  fifo_cas_chain #(.WIDTH(W), .DEPTH(8), .NCELLS(1)) u_solo (
    .clk(clk), .rst_n(rst_n), .wr_n(s_wr), .din(din), .rd_n(s_rd),
    .rewind_n(s_rt), .dout(s_q), .empty_n(s_e), .full_n(s_f), .half_n(s_h));

  logic [W-1:0] o_q;
  logic o_e, o_f, o_h;
  assign o_q = tgt ? s_q : c_q;
  assign o_e = tgt ? s_e : c_e;
  assign o_f = tgt ? s_f : c_f;
  assign o_h = tgt ? s_h : c_h;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic which);
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; tgt = which;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [W-1:0] d);
    @(negedge clk); din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_rd();
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop(input string tag, input logic [W-1:0] exp);
    chk(tag, o_q, exp);
    do_rd();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 ring empty_n", o_e, 0); chk("R1 ring full_n", o_f, 1); chk("R1 ring half_n", o_h, 1);
    do_reset(1'b1);
    chk("R1 solo empty_n", o_e, 0); chk("R1 solo full_n", o_f, 1); chk("R1 solo half_n", o_h, 1);
  endtask

  task automatic t_order();
    do_reset(1'b1);
    do_wr(9'h011); do_wr(9'h1F0); do_wr(9'h0A5);
    chk("R2 not empty", o_e, 1);
    pop("R2 order", 9'h011); pop("R2 order", 9'h1F0); pop("R2 order", 9'h0A5);
    chk("R2 empty after drain", o_e, 0);
  endtask

  task automatic t_full();
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) begin
      do_wr(W'(i * 5 + 1));
      if (i == 3) chk("R7 half_n at 4", o_h, 1);
      if (i == 4) chk("R7 half_n at 5", o_h, 0);
    end
    chk("R3 full_n when full", o_f, 0);
    chk("R12 empty_n while full", o_e, 1);
    do_wr(9'h1AA);
    chk("R3 full_n after dropped write", o_f, 0);
    for (int i = 0; i < 8; i++) pop("R3 contents kept", W'(i * 5 + 1));
    chk("R4 empty after drain", o_e, 0);
    do_rd();
    chk("R4 empty after read on empty", o_e, 0);
    do_wr(9'h055);
    pop("R4 write after empty read", 9'h055);
    chk("R4 empty again", o_e, 0);
  endtask

  task automatic t_rflow();
    do_reset(1'b1);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); din = 9'h123; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 empty_n after write edge", o_e, 1);
    chk("R5 dout flow-through", o_q, 9'h123);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 empty_n after read release", o_e, 0);
  endtask

  task automatic t_wflow();
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) do_wr(W'(i + 9'h40));
    @(negedge clk); din = 9'h0F0; wr_n = 1'b0;
    do_rd();
    chk("R6 full_n after read", o_f, 1);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 full_n after write release", o_f, 0);
    for (int i = 1; i < 8; i++) pop("R6 drain", W'(i + 9'h40));
    pop("R6 pending word", 9'h0F0);
  endtask

  task automatic t_rewind();
    do_reset(1'b1);
    do_wr(9'h00A); do_wr(9'h00B); do_wr(9'h00C);
    pop("R8 pre", 9'h00A); pop("R8 pre", 9'h00B);
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
    @(negedge clk);
    chk("R8 not empty after rewind", o_e, 1);
    pop("R8 reread", 9'h00A); pop("R8 reread", 9'h00B); pop("R8 reread", 9'h00C);
    chk("R8 empty at write position", o_e, 0);
  endtask

  task automatic t_ring();
    do_reset(1'b0);
    for (int i = 0; i < 12; i++) begin
      do_wr(W'(i + 9'h100));
      if (i == 6)  chk("R11 ring half_n stays high", o_h, 1);
      if (i == 10) chk("R9 composite full_n at 11", o_f, 1);
    end
    chk("R9 composite full_n at 12", o_f, 0);
    do_wr(9'h0EE);
    chk("R3 ring dropped write", o_f, 0);
    for (int i = 0; i < 6; i++) pop("R10 ring order", W'(i + 9'h100));
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
    @(negedge clk);
    for (int i = 6; i < 11; i++) pop("R11 rewind ignored", W'(i + 9'h100));
    chk("R9 composite empty_n at 1", o_e, 1);
    pop("R9 ring last", 9'h10B);
    chk("R9 composite empty_n at 0", o_e, 0);
    do_rd();
    do_wr(9'h077);
    pop("R4 ring after empty read", 9'h077);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_rflow();
    t_wflow();
    t_rewind();
    t_ring();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule